// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers for the I/O companion device of a workstation. Each register sits behind its own select line on a simple write-strobe bus with a combinational read path. The bank holds:

- a configuration byte, a diagnostic byte and a modem-control byte;
- two auxiliary control bytes;
- a 16-bit LED word;
- a 32-bit system control word.

Several register bits act rather than store. One auxiliary bit fires a one-clock terminal-count strobe toward a floppy controller. The power-off bit raises a shutdown request. Bit 0 of the system control word raises a system reset request and latches a reset-status code.

A power-fail pin feeds a sticky flag. On every change of the pin the flag is re-evaluated against the power-interrupt enable in the configuration byte, and software clears it through the second auxiliary register. The interrupt output is the flag qualified by that same enable. A block reset clears the volatile control registers. The diagnostic byte, the LED word and the system control word keep their contents, so software can read the reset-status code after the reset it requested.

Top module: `auxctl_regbank`

## Requirements
- R1: `reg_sel` is one-hot with this bit mapping: bit 0 configuration, bit 1 diagnostic, bit 2 modem control, bit 3 first auxiliary, bit 4 second auxiliary, bit 5 LED, bit 6 system control. The three plain bytes (configuration, diagnostic, modem) store `bus_wdata[7:0]` on a write and read back that value zero-extended. With no select bit set, `bus_rdata` is 0.
- R2: A write to the first auxiliary register with bit 1 set drives `tc_pulse` high for exactly the one cycle after the write edge. Bit 1 is stored as 0, and the other seven bits are stored as written.
- R3: A write to the second auxiliary register takes only bit 0 (power off) and bit 1 (clear power fail). All other written bits are ignored. The register reads back the power-off bit in bit 0 and the power-fail flag in bit 5; every other bit reads 0.
- R4: A write to the second auxiliary register never sets the power-fail flag. If written bit 1 is 0 the flag is preserved; if it is 1 the flag is cleared.
- R5: A write to the second auxiliary register that stores bit 0 as 1 drives `pwroff_req` high for exactly the one cycle after the write edge.
- R6: On a change of `pf_in`, the flag becomes 1 if `pf_in` is 1 and configuration bit 3 is 1, and becomes 0 otherwise. A clear written in the same cycle takes precedence. While `pf_in` is steady the flag is unaffected.
- R7: `irq` is 1 exactly when the power-fail flag is 1 and configuration bit 3 is 1.
- R8: A write of bit 0 = 1 to offset 0 of the system control register loads it with 0x00000002 and drives `sysrst_req` high for the one cycle after the write edge. A write with bit 0 = 0 leaves the register unchanged.
- R9: The LED register holds `bus_wdata[15:0]` at offset 0. In the LED and system control windows, any nonzero `bus_off` reads as 0, and writes there change nothing.
- R10: Reset (`rst_n` low) clears the configuration, modem-control and both auxiliary registers, and all request outputs. The diagnostic, LED and system control registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reg_sel | input | 7 | One-hot register select |
| bus_off | input | 2 | Offset within the LED and system control windows |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| pf_in | input | 1 | Power-fail pin, active high |
| irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Terminal-count strobe to the floppy controller |
| pwroff_req | output | 1 | Power-off request pulse |
| sysrst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its default parameters: 8-bit control bytes, a 16-bit LED word, a 32-bit system word and a 2-bit window offset. With a 2-bit offset, nonzero offsets exist in both wide windows, so the zero-read and dropped-write behaviour is exercised. With the enable at bit 3 and the flag at bit 5 of an 8-bit register, writes of all-ones patterns can try to set the flag and to keep the clear bit, and both attempts are observed at the read port.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
   localparam int NUM_SEL = 7;
   typedef enum logic [2:0] {
      SEL_CFG   = 3'd0,
      SEL_DIAG  = 3'd1,
      SEL_MODEM = 3'd2,
      SEL_AUX1  = 3'd3,
      SEL_AUX2  = 3'd4,
      SEL_LED   = 3'd5,
      SEL_SYSC  = 3'd6
   } sel_e;
endpackage

// File: rtl/auxctl_field.sv
// Plain storage field; CLEAR_ON_RST picks a resettable or a retaining variant.
module auxctl_field #(
   parameter int W            = 8,
   parameter bit CLEAR_ON_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (CLEAR_ON_RST) begin : g_clr
         logic [W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q_r <= '0;
            else if (we) q_r <= d;
         end
         assign q = q_r;
      end else begin : g_keep
         logic [W-1:0] q_r = '0;
         always_ff @(posedge clk) begin
            if (we) q_r <= d;
         end
         assign q = q_r;
      end
   endgenerate
endmodule

// File: rtl/auxctl_pwrctl.sv
// Second auxiliary register: power-off bit, sticky power-fail flag, interrupt.
module auxctl_pwrctl #(
   parameter int W         = 8,
   parameter int POFF_BIT  = 0,
   parameter int PCLR_BIT  = 1,
   parameter int PFLAG_BIT = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         pf_in,
   input  logic         int_en,
   output logic [W-1:0] rd,
   output logic         irq,
   output logic         poff_req,
   output logic         flag,
   output logic         pf_prev
);
   logic poff_q;
   logic pf_evt;

   assign pf_evt = (pf_in != pf_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poff_q   <= 1'b0;
         flag     <= 1'b0;
         pf_prev  <= 1'b0;
         poff_req <= 1'b0;
      end else begin
         pf_prev  <= pf_in;
         poff_req <= wr & wdata[POFF_BIT];
         if (wr) poff_q <= wdata[POFF_BIT];
         if (wr && wdata[PCLR_BIT]) flag <= 1'b0;
         else if (pf_evt)          flag <= pf_in & int_en;
      end
   end

   always_comb begin
      rd            = '0;
      rd[POFF_BIT]  = poff_q;
      rd[PFLAG_BIT] = flag;
   end

   assign irq = flag & int_en;
endmodule

// File: rtl/auxctl_regbank.sv
module auxctl_regbank
   import auxctl_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          BYTE_W     = 8,
   parameter int          LED_W      = 16,
   parameter int          SYS_W      = 32,
   parameter int          OFF_W      = 2,
   parameter int          PWR_EN_BIT = 3,
   parameter int          TC_BIT     = 1,
   parameter int          POFF_BIT   = 0,
   parameter int          PCLR_BIT   = 1,
   parameter int          PFLAG_BIT  = 5,
   parameter int          SRST_BIT   = 0,
   parameter logic [31:0] SSTAT_VAL  = 32'h2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SEL-1:0]  reg_sel,
   input  logic [OFF_W-1:0]    bus_off,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                pf_in,
   output logic                irq,
   output logic                tc_pulse,
   output logic                pwroff_req,
   output logic                sysrst_req
);
   localparam int NUM_PLAIN = 3;
   localparam logic [BYTE_W-1:0] TC_MASK = BYTE_W'(1) << TC_BIT;

   // elaboration-time parameter checks
   if (LED_W > DATA_W || SYS_W > DATA_W || BYTE_W > DATA_W) begin : g_bad_w
      $error("register width exceeds bus width");
   end
   if (PWR_EN_BIT >= BYTE_W || TC_BIT >= BYTE_W || PFLAG_BIT >= BYTE_W ||
       POFF_BIT >= BYTE_W || PCLR_BIT >= BYTE_W) begin : g_bad_bit
      $error("control bit position outside byte register");
   end
   if (POFF_BIT == PFLAG_BIT || PCLR_BIT == POFF_BIT) begin : g_bad_map
      $error("power control bits overlap");
   end
   if (OFF_W < 1) begin : g_bad_off
      $error("offset width must be at least one");
   end

   logic              wr_any;
   logic              off_zero;
   logic [BYTE_W-1:0] plain_q [NUM_PLAIN];
   logic [BYTE_W-1:0] aux1_q;
   logic [BYTE_W-1:0] aux2_rd;
   logic [LED_W-1:0]  led_q;
   logic [SYS_W-1:0]  sysc_q;
   logic              pf_flag;
   logic              pf_prev_q;
   logic              tc_q;
   logic              srst_q;
   logic              srst_hit;

   assign wr_any   = bus_we;
   assign off_zero = (bus_off == '0);

   // configuration and modem bytes clear on reset; diagnostic byte retains
   for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
      auxctl_field #(
         .W(BYTE_W),
         .CLEAR_ON_RST(i != int'(SEL_DIAG))
      ) u_fld (
         .clk(clk), .rst_n(rst_n),
         .we(wr_any & reg_sel[i]),
         .d(bus_wdata[BYTE_W-1:0]),
         .q(plain_q[i])
      );
   end

   auxctl_field #(.W(BYTE_W), .CLEAR_ON_RST(1'b1)) u_aux1 (
      .clk(clk), .rst_n(rst_n),
      .we(wr_any & reg_sel[SEL_AUX1]),
      .d(bus_wdata[BYTE_W-1:0] & ~TC_MASK),
      .q(aux1_q)
   );

   auxctl_pwrctl #(
      .W(BYTE_W), .POFF_BIT(POFF_BIT), .PCLR_BIT(PCLR_BIT), .PFLAG_BIT(PFLAG_BIT)
   ) u_pwr (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_any & reg_sel[SEL_AUX2]),
      .wdata(bus_wdata[BYTE_W-1:0]),
      .pf_in(pf_in),
      .int_en(plain_q[SEL_CFG][PWR_EN_BIT]),
      .rd(aux2_rd),
      .irq(irq),
      .poff_req(pwroff_req),
      .flag(pf_flag),
      .pf_prev(pf_prev_q)
   );

   auxctl_field #(.W(LED_W), .CLEAR_ON_RST(1'b0)) u_led (
      .clk(clk), .rst_n(rst_n),
      .we(wr_any & reg_sel[SEL_LED] & off_zero),
      .d(bus_wdata[LED_W-1:0]),
      .q(led_q)
   );

   assign srst_hit = wr_any & reg_sel[SEL_SYSC] & off_zero & bus_wdata[SRST_BIT];

   auxctl_field #(.W(SYS_W), .CLEAR_ON_RST(1'b0)) u_sysc (
      .clk(clk), .rst_n(rst_n),
      .we(srst_hit),
      .d(SSTAT_VAL[SYS_W-1:0]),
      .q(sysc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q   <= 1'b0;
         srst_q <= 1'b0;
      end else begin
         tc_q   <= wr_any & reg_sel[SEL_AUX1] & bus_wdata[TC_BIT];
         srst_q <= srst_hit;
      end
   end

   assign tc_pulse   = tc_q;
   assign sysrst_req = srst_q;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PLAIN; i++) begin
         if (reg_sel[i]) bus_rdata = DATA_W'(plain_q[i]);
      end
      if (reg_sel[SEL_AUX1]) bus_rdata = DATA_W'(aux1_q);
      if (reg_sel[SEL_AUX2]) bus_rdata = DATA_W'(aux2_rd);
      if (reg_sel[SEL_LED] && off_zero)  bus_rdata = DATA_W'(led_q);
      if (reg_sel[SEL_SYSC] && off_zero) bus_rdata = DATA_W'(sysc_q);
   end
endmodule

// File: rtl/auxctl_regbank_chk.sv
module auxctl_regbank_chk #(
   parameter int NUM_SEL = 7,
   parameter int OFF_W   = 2,
   parameter int DATA_W  = 32,
   parameter int SYS_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_SEL-1:0] reg_sel,
   input logic [OFF_W-1:0]  bus_off,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              pf_in,
   input logic              irq,
   input logic              tc_pulse,
   input logic              pwroff_req,
   input logic              sysrst_req,
   input logic              pf_flag,
   input logic              pf_prev_q,
   input logic [SYS_W-1:0]  sysc_q
);
   assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_sel));

   assert_tc_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> $past(bus_we && reg_sel[3] && bus_wdata[1]));

   assert_flag_from_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_flag) |-> $past(pf_in != pf_prev_q));

   assert_poff_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pwroff_req |-> $past(bus_we && reg_sel[4] && bus_wdata[0]));

   assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pf_flag);

   assert_srst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sysrst_req |-> $past(bus_we && reg_sel[6] && bus_off == '0 && bus_wdata[0]));

   assert_sysc_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sysc_q == '0) || (sysc_q == SYS_W'(2)));
endmodule

bind auxctl_regbank auxctl_regbank_chk #(
   .NUM_SEL(auxctl_pkg::NUM_SEL), .OFF_W(OFF_W), .DATA_W(DATA_W), .SYS_W(SYS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .bus_off(bus_off),
   .bus_we(bus_we), .bus_wdata(bus_wdata), .pf_in(pf_in), .irq(irq),
   .tc_pulse(tc_pulse), .pwroff_req(pwroff_req), .sysrst_req(sysrst_req),
   .pf_flag(pf_flag), .pf_prev_q(pf_prev_q), .sysc_q(sysc_q)
);

// File: tb/tb_auxctl_regbank.sv
module tb_auxctl_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  reg_sel = '0;
   logic [1:0]  bus_off = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pf_in = 1'b0;
   logic        irq, tc_pulse, pwroff_req, sysrst_req;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   auxctl_regbank dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .bus_off(bus_off),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pf_in(pf_in), .irq(irq), .tc_pulse(tc_pulse),
      .pwroff_req(pwroff_req), .sysrst_req(sysrst_req)
   );

   typedef struct packed {
      logic [2:0]  sel;
      logic [1:0]  off;
      logic [31:0] wd;
      logic [31:0] rd;
      logic        tc;
      logic        poff;
      logic        srst;
      logic        irq;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 2'd0, 32'h0000_00A5, 32'h0000_00A5, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd1, 2'd0, 32'h0000_003C, 32'h0000_003C, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd2, 2'd0, 32'hFFFF_FFC3, 32'h0000_00C3, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd3, 2'd0, 32'h0000_00FF, 32'h0000_00FD, 1'b1, 1'b0, 1'b0, 1'b0},
      '{3'd3, 2'd0, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd4, 2'd0, 32'h0000_00FE, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd4, 2'd0, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b0},
      '{3'd4, 2'd0, 32'h0000_00FC, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd5, 2'd0, 32'hBEEF_1234, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd5, 2'd1, 32'h0000_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd6, 2'd0, 32'hFFFF_FFFE, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd6, 2'd2, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
      '{3'd6, 2'd0, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b0, 1'b1, 1'b0},
      '{3'd0, 2'd0, 32'h0000_0008, 32'h0000_0008, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   function automatic string tag_of(input logic [2:0] s);
      case (s)
         3'd3:    return "R2";
         3'd4:    return "R3";
         3'd5:    return "R9";
         3'd6:    return "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // write on one edge, then hold the select for a read at the next low phase
   task automatic wr(input int s, input logic [1:0] off, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 7'(1 << s); bus_off = off; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int s, input logic [1:0] off);
      reg_sel = 7'(1 << s); bus_off = off;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      // R10 reset state of cleared registers and outputs
      rd(0, 0); chk("R10 cfg reset", bus_rdata, 0);
      rd(3, 0); chk("R10 aux1 reset", bus_rdata, 0);
      rd(4, 0); chk("R10 aux2 reset", bus_rdata, 0);
      chk("R10 outputs reset", {28'd0, irq, tc_pulse, pwroff_req, sysrst_req}, 0);
      reg_sel = '0; #1;
      chk("R1 no select reads zero", bus_rdata, 0);

      for (int i = 0; i < NV; i++) begin
         wr(int'(VECS[i].sel), VECS[i].off, VECS[i].wd);
         chk("R2 tc pulse", 32'(tc_pulse), 32'(VECS[i].tc));
         chk("R5 poff pulse", 32'(pwroff_req), 32'(VECS[i].poff));
         chk("R8 srst pulse", 32'(sysrst_req), 32'(VECS[i].srst));
         chk("R7 irq", 32'(irq), 32'(VECS[i].irq));
         rd(int'(VECS[i].sel), VECS[i].off);
         chk(tag_of(VECS[i].sel), bus_rdata, VECS[i].rd);
      end

      // R9 dropped write at offset 1 left offset 0 intact
      rd(5, 0); chk("R9 led offset0 kept", bus_rdata, 32'h1234);

      // R2 strobe is exactly one cycle wide
      wr(3, 0, 32'h02);
      chk("R2 tc high", 32'(tc_pulse), 1);
      @(negedge clk);
      chk("R2 tc one cycle", 32'(tc_pulse), 0);
      // R5 / R8 single-cycle requests
      wr(4, 0, 32'h01);
      @(negedge clk);
      chk("R5 poff one cycle", 32'(pwroff_req), 0);
      wr(6, 0, 32'h01);
      @(negedge clk);
      chk("R8 srst one cycle", 32'(sysrst_req), 0);

      // R6 pin rise with enable set (cfg = 0x08 from table)
      wr(4, 0, 32'h00);
      @(negedge clk); pf_in = 1'b1;
      @(negedge clk);
      rd(4, 0); chk("R6 flag set by pin", bus_rdata, 32'h20);
      chk("R7 irq on flag", 32'(irq), 1);
      // R4 write without clear preserves flag
      wr(4, 0, 32'hFC);
      rd(4, 0); chk("R4 flag preserved", bus_rdata, 32'h20);
      // R7 disabling enable masks irq, flag stays
      wr(0, 0, 32'h00);
      chk("R7 irq masked", 32'(irq), 0);
      rd(4, 0); chk("R7 flag kept while masked", bus_rdata, 32'h20);
      wr(0, 0, 32'h08);
      chk("R7 irq unmasked", 32'(irq), 1);
      // R4 clear bit clears flag, keeps power-off bit
      wr(4, 0, 32'h03);
      chk("R5 poff with clear", 32'(pwroff_req), 1);
      rd(4, 0); chk("R4 flag cleared", bus_rdata, 32'h01);
      chk("R7 irq after clear", 32'(irq), 0);
      // R6 steady pin does not re-set flag
      repeat (3) @(negedge clk);
      rd(4, 0); chk("R6 steady pin", bus_rdata, 32'h01);
      // R6 pin fall, then rise with enable off
      pf_in = 1'b0;
      @(negedge clk);
      wr(0, 0, 32'h00);
      pf_in = 1'b1;
      @(negedge clk);
      rd(4, 0); chk("R6 rise with enable off", bus_rdata, 32'h01);
      pf_in = 1'b0;
      @(negedge clk);

      // R10 retention across reset
      wr(1, 0, 32'h5A);
      wr(2, 0, 32'h77);
      do_reset();
      rd(1, 0); chk("R10 diag kept", bus_rdata, 32'h5A);
      rd(6, 0); chk("R10 sysc kept", bus_rdata, 32'h2);
      rd(5, 0); chk("R10 led kept", bus_rdata, 32'h1234);
      rd(2, 0); chk("R10 modem cleared", bus_rdata, 0);
      rd(4, 0); chk("R10 aux2 cleared", bus_rdata, 0);

      finish_run();
   end
endmodule